// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Classifier

This block observes the five active-low control pins of a 16-bit dynamic RAM that has one row strobe, a separate column strobe for each byte, a write enable and an output enable. The pins are asynchronous to the system clock, so each one passes through a multi-flop synchronizer before any edge is taken from it. From the sequence of edges inside one row-strobe-low period the block decides what kind of memory cycle took place. When the row strobe returns high it emits a single-cycle pulse carrying a 4-bit cycle code and a 2-bit byte-lane mask.

The column strobes share one mode window. The window opens on whichever strobe falls first and closes only when the last of them has risen. Output drive and write strobes are still decided per byte lane, each from its own column strobe. The block therefore also drives registered per-lane output-enable and write-strobe signals. These can steer a data-bus model or be checked against a bus monitor.

Top module: `dram_cycle_classifier`

## Requirements
- R1: Every rising edge of the row strobe that ends a cycle produces exactly one `cyc_valid_o` pulse, one clock wide, with the code and mask of that cycle.
- R2: If either column strobe (only one is enough) is already low when the row strobe falls, the cycle reports code 7 (CAS-before-RAS refresh) with mask 00, and neither lane gets an output enable or write strobe during it.
- R3: A cycle in which no column strobe falls reports code 6 (row-only refresh) with mask 00, and both lanes stay disabled.
- R4: The mask has bit 0 for the lower byte (lower column strobe) and bit 1 for the upper byte. It is the OR of every lane seen active while the mode window was open.
- R5: With OE low and WE high while column strobes are active, the cycle reports code 1 (read). `lane_oe_o` is high only on lanes whose own column strobe is low.
- R6: If OE stays high and WE stays high through the column period, the cycle reports code 2 (read with outputs off) and `lane_oe_o` stays 00.
- R7: If WE is already low when the first column strobe falls, the cycle reports code 3 (early write). `lane_oe_o` stays 00 even with OE low, and `lane_we_o` follows each lane's column strobe.
- R8: If WE falls while the mode window is open, with OE never low before it, the cycle reports code 4 (delayed write). The write strobe goes only to the lanes whose column strobe is low.
- R9: If OE was low with WE high inside the window and WE then falls inside the same window, the cycle reports code 5 (read-modify-write). The data lanes are first enabled for output and then for write.
- R10: If WE falls after a column window has closed and while no column strobe is low, in a non-refresh cycle, the cycle reports code 15 (unrecognized).
- R11: While the row strobe is high, `lane_oe_o` and `lane_we_o` are 00, whatever the other pins do.
- R12: Staggered column strobes form one window. A WE fall while only the later strobe is still low counts as a delayed write and not as an unrecognized cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n_i | input | 1 | Row strobe, active low, asynchronous |
| ucas_n_i | input | 1 | Upper-byte column strobe, active low |
| lcas_n_i | input | 1 | Lower-byte column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| cyc_valid_o | output | 1 | One-cycle pulse when a cycle ends |
| cyc_type_o | output | 4 | Cycle code, valid with the pulse |
| lane_mask_o | output | 2 | Byte lanes used by the cycle, bit 0 lower |
| lane_oe_o | output | 2 | Registered per-lane output enable |
| lane_we_o | output | 2 | Registered per-lane write strobe |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default 2. A result is therefore at least one cycle later than with the default. Because a monitor pairs the pulses with queued expectations, the checks stay valid whatever the pipeline depth. Each pin change is held for eight clocks, well past the synchronizer and edge latency. This brings the lane outputs within reach of a settled mid-phase sample and leaves the edge ordering inside a cycle as the only thing that varies. The stimulus covers every code, single and dual lanes, CAS-before-RAS refresh with only one strobe low, and a staggered strobe window.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

   localparam int LANES  = 2;
   localparam int TYPE_W = 4;

   typedef enum logic [TYPE_W-1:0] {
      CYC_IDLE     = 4'd0,
      CYC_RD       = 4'd1,
      CYC_RD_HIZ   = 4'd2,
      CYC_WR_EARLY = 4'd3,
      CYC_WR_LATE  = 4'd4,
      CYC_RMW      = 4'd5,
      CYC_RFSH_ROW = 4'd6,
      CYC_RFSH_CBR = 4'd7,
      CYC_BAD      = 4'd15
   } cyc_kind_e;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_ANY  = 2'd2
   } edge_kind_e;

   // Priority order matters: refresh first, then fault, then the write forms.
   function automatic cyc_kind_e decode_kind(
      input logic cbr,
      input logic bad,
      input logic seen,
      input logic early,
      input logic late,
      input logic oe_seen
   );
      cyc_kind_e k;
      if (cbr)          k = CYC_RFSH_CBR;
      else if (bad)     k = CYC_BAD;
      else if (!seen)   k = CYC_RFSH_ROW;
      else if (early)   k = CYC_WR_EARLY;
      else if (late)    k = oe_seen ? CYC_RMW : CYC_WR_LATE;
      else              k = oe_seen ? CYC_RD : CYC_RD_HIZ;
      return k;
   endfunction

endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
   parameter int            W      = 1,
   parameter int            STAGES = 2,
   parameter logic [W-1:0]  INIT   = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("dcc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("dcc_sync: W must be at least 1");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= INIT;
      else        pipe[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[k] <= INIT;
         else        pipe[k] <= pipe[k-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/dcc_edge.sv
module dcc_edge #(
   parameter dcc_pkg::edge_kind_e KIND = dcc_pkg::EDGE_FALL,
   parameter logic                INIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic ev
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= INIT;
      else        prev_q <= d;
   end

   if (KIND == dcc_pkg::EDGE_RISE) begin : g_rise
      assign ev = d & ~prev_q;
   end else if (KIND == dcc_pkg::EDGE_FALL) begin : g_fall
      assign ev = ~d & prev_q;
   end else begin : g_any
      assign ev = d ^ prev_q;
   end

endmodule

// File: rtl/dcc_classify.sv
module dcc_classify
   import dcc_pkg::*;
#(
   parameter int NL = LANES,
   parameter int TW = TYPE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ras_a,
   input  logic [NL-1:0] cas_a,
   input  logic          we_a,
   input  logic          oe_a,
   input  logic          ras_start,
   input  logic          ras_end,
   input  logic          we_start,
   input  logic          win_open,
   output logic          valid_o,
   output logic [TW-1:0] type_o,
   output logic [NL-1:0] mask_o,
   output logic [NL-1:0] lane_oe_o,
   output logic [NL-1:0] lane_we_o
);

   if (TW < 4) begin : g_bad_tw
      $error("dcc_classify: TW must hold the 4-bit code");
   end

   logic          in_cyc_q, cbr_q, seen_q, early_q, late_q, oe_seen_q, bad_q;
   logic [NL-1:0] mask_q;
   logic          valid_q;
   logic [TW-1:0] type_q;
   logic [NL-1:0] mask_out_q;
   logic [NL-1:0] oe_nxt, we_nxt;
   logic          win_act, live;
   cyc_kind_e     kind_now;

   assign win_act  = |cas_a;
   assign live     = in_cyc_q & ~cbr_q;
   assign kind_now = decode_kind(cbr_q, bad_q, seen_q, early_q, late_q, oe_seen_q);

   // Per-cycle history
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cyc_q  <= 1'b0;
         cbr_q     <= 1'b0;
         seen_q    <= 1'b0;
         early_q   <= 1'b0;
         late_q    <= 1'b0;
         oe_seen_q <= 1'b0;
         bad_q     <= 1'b0;
         mask_q    <= '0;
      end else if (ras_start) begin
         in_cyc_q  <= 1'b1;
         cbr_q     <= win_act;
         seen_q    <= 1'b0;
         early_q   <= 1'b0;
         late_q    <= 1'b0;
         oe_seen_q <= 1'b0;
         bad_q     <= 1'b0;
         mask_q    <= '0;
      end else if (ras_end) begin
         in_cyc_q  <= 1'b0;
      end else if (live) begin
         if (win_open) begin
            seen_q <= 1'b1;
            if (!seen_q && we_a) early_q <= 1'b1;
         end
         if (win_act) begin
            mask_q <= mask_q | cas_a;
            if (oe_a && !we_a && !early_q && !late_q) oe_seen_q <= 1'b1;
         end
         if (we_start) begin
            if (win_act && !win_open && !early_q) late_q <= 1'b1;
            else if (!win_act && seen_q)         bad_q  <= 1'b1;
         end
      end
   end

   // Result pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q    <= 1'b0;
         type_q     <= TW'(CYC_IDLE);
         mask_out_q <= '0;
      end else begin
         valid_q <= ras_end & in_cyc_q;
         if (ras_end && in_cyc_q) begin
            type_q     <= TW'(kind_now);
            mask_out_q <= (cbr_q || !seen_q) ? '0 : mask_q;
         end
      end
   end

   // Per-lane control, each lane gated by its own column strobe
   for (genvar i = 0; i < NL; i++) begin : g_lane
      assign oe_nxt[i] = live & ras_a & cas_a[i] & oe_a & ~we_a & ~early_q & ~late_q;
      assign we_nxt[i] = live & ras_a & cas_a[i] & we_a & ~bad_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_oe_o <= '0;
         lane_we_o <= '0;
      end else begin
         lane_oe_o <= oe_nxt;
         lane_we_o <= we_nxt;
      end
   end

   assign valid_o = valid_q;
   assign type_o  = type_q;
   assign mask_o  = mask_out_q;

   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   a_r2_cbr_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && type_o == TW'(CYC_RFSH_CBR)) |-> mask_o == '0);

   a_r3_row_only_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && type_o == TW'(CYC_RFSH_ROW)) |-> mask_o == '0);

   a_r7_early_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      early_q |-> lane_oe_o == '0);

   a_r9_lane_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_oe_o & lane_we_o) == '0);

   a_r11_row_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_a |=> (lane_oe_o == '0 && lane_we_o == '0));

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
   import dcc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n_i,
   input  logic              ucas_n_i,
   input  logic              lcas_n_i,
   input  logic              we_n_i,
   input  logic              oe_n_i,
   output logic              cyc_valid_o,
   output logic [TYPE_W-1:0] cyc_type_o,
   output logic [LANES-1:0]  lane_mask_o,
   output logic [LANES-1:0]  lane_oe_o,
   output logic [LANES-1:0]  lane_we_o
);

   localparam int NPIN  = 3 + LANES;
   localparam int P_RAS = 0;
   localparam int P_CAS = 1;
   localparam int P_WE  = P_CAS + LANES;
   localparam int P_OE  = P_WE + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dram_cycle_classifier: SYNC_STAGES must be at least 2");
   end
   if (LANES != 2) begin : g_bad_lanes
      $error("dram_cycle_classifier: port list assumes two byte lanes");
   end

   logic [NPIN-1:0]  pins_raw, pins_s;
   logic             ras_a, we_a, oe_a;
   logic [LANES-1:0] cas_a;
   logic             ras_start, ras_end, we_start, win_open, win_idle;

   assign pins_raw = {oe_n_i, we_n_i, ucas_n_i, lcas_n_i, ras_n_i};

   dcc_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .INIT({NPIN{1'b1}})) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s));

   assign ras_a    = ~pins_s[P_RAS];
   assign cas_a    = ~pins_s[P_CAS +: LANES];
   assign we_a     = ~pins_s[P_WE];
   assign oe_a     = ~pins_s[P_OE];
   assign win_idle = ~(|cas_a);

   dcc_edge #(.KIND(EDGE_FALL), .INIT(1'b1)) u_ras_fall (
      .clk(clk), .rst_n(rst_n), .d(pins_s[P_RAS]), .ev(ras_start));
   dcc_edge #(.KIND(EDGE_RISE), .INIT(1'b1)) u_ras_rise (
      .clk(clk), .rst_n(rst_n), .d(pins_s[P_RAS]), .ev(ras_end));
   dcc_edge #(.KIND(EDGE_FALL), .INIT(1'b1)) u_we_fall (
      .clk(clk), .rst_n(rst_n), .d(pins_s[P_WE]), .ev(we_start));
   dcc_edge #(.KIND(EDGE_FALL), .INIT(1'b1)) u_win_open (
      .clk(clk), .rst_n(rst_n), .d(win_idle), .ev(win_open));

   dcc_classify #(.NL(LANES), .TW(TYPE_W)) u_cls (
      .clk(clk), .rst_n(rst_n),
      .ras_a(ras_a), .cas_a(cas_a), .we_a(we_a), .oe_a(oe_a),
      .ras_start(ras_start), .ras_end(ras_end),
      .we_start(we_start), .win_open(win_open),
      .valid_o(cyc_valid_o), .type_o(cyc_type_o), .mask_o(lane_mask_o),
      .lane_oe_o(lane_oe_o), .lane_we_o(lane_we_o));

endmodule

// File: tb/dram_cycle_classifier_tb.sv
`timescale 1ns/1ps
module dram_cycle_classifier_tb;

   typedef struct {
      logic [3:0] t;
      logic [1:0] m;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic       cyc_valid;
   logic [3:0] cyc_type;
   logic [1:0] lane_mask, lane_oe, lane_we;

   int   n_run  = 0;
   int   n_fail = 0;
   int   n_push = 0;
   int   n_pulse = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #4 clk = ~clk;

   dram_cycle_classifier #(.SYNC_STAGES(3)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ras_n_i(ras_n), .ucas_n_i(ucas_n), .lcas_n_i(lcas_n),
      .we_n_i(we_n), .oe_n_i(oe_n),
      .cyc_valid_o(cyc_valid), .cyc_type_o(cyc_type), .lane_mask_o(lane_mask),
      .lane_oe_o(lane_oe), .lane_we_o(lane_we));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // pins in order ras, ucas, lcas, we, oe (all active low)
   task automatic drive(input logic r, input logic u, input logic l, input logic w, input logic o);
      {ras_n, ucas_n, lcas_n, we_n, oe_n} = {r, u, l, w, o};
      repeat (8) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_cyc(input logic [3:0] t, input logic [1:0] m, input string req);
      exp_t e;
      e.t = t; e.m = m; e.req = req;
      sb.push_back(e);
      n_push++;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && cyc_valid) begin
         n_pulse++;
         if (sb.size() == 0) begin
            check("R1 unexpected pulse", 8'd1, 8'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check({e.req, " type"}, {4'd0, cyc_type}, {4'd0, e.t});
            check({e.req, " mask"}, {6'd0, lane_mask}, {6'd0, e.m});
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         check("watchdog", 8'd1, 8'd0);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R11 reset lane_oe", {6'd0, lane_oe}, 8'd0);
      check("R11 reset lane_we", {6'd0, lane_we}, 8'd0);
      check("R1 reset valid", {7'd0, cyc_valid}, 8'd0);

      // R5 word read
      drive(0,1,1,1,1);
      drive(0,0,0,1,0);
      check("R5 word read lane_oe", {6'd0, lane_oe}, 8'h3);
      drive(0,1,1,1,0);
      expect_cyc(4'd1, 2'b11, "R5 word read");
      drive(1,1,1,1,1);

      // R5/R4 lower read
      drive(0,1,1,1,1);
      drive(0,1,0,1,0);
      check("R5 lower read lane_oe", {6'd0, lane_oe}, 8'h1);
      drive(0,1,1,1,1);
      expect_cyc(4'd1, 2'b01, "R4 lower read");
      drive(1,1,1,1,1);

      // R6 upper read, outputs off
      drive(0,1,1,1,1);
      drive(0,0,1,1,1);
      check("R6 outputs off lane_oe", {6'd0, lane_oe}, 8'h0);
      drive(0,1,1,1,1);
      expect_cyc(4'd2, 2'b10, "R6 read hiz");
      drive(1,1,1,1,1);

      // R7 early write word with OE low
      drive(0,1,1,0,0);
      drive(0,0,0,0,0);
      check("R7 early write lane_oe", {6'd0, lane_oe}, 8'h0);
      check("R7 early write lane_we", {6'd0, lane_we}, 8'h3);
      drive(0,1,1,0,0);
      drive(0,1,1,1,1);
      expect_cyc(4'd3, 2'b11, "R7 early word");
      drive(1,1,1,1,1);

      // R7 early write lower only
      drive(0,1,1,0,1);
      drive(0,1,0,0,1);
      check("R7 lower early lane_we", {6'd0, lane_we}, 8'h1);
      drive(0,1,1,1,1);
      expect_cyc(4'd3, 2'b01, "R7 early lower");
      drive(1,1,1,1,1);

      // R8 delayed write upper
      drive(0,1,1,1,1);
      drive(0,0,1,1,1);
      drive(0,0,1,0,1);
      check("R8 delayed lane_we", {6'd0, lane_we}, 8'h2);
      drive(0,1,1,0,1);
      drive(0,1,1,1,1);
      expect_cyc(4'd4, 2'b10, "R8 delayed write");
      drive(1,1,1,1,1);

      // R9 read-modify-write word
      drive(0,1,1,1,1);
      drive(0,0,0,1,0);
      check("R9 rmw read phase lane_oe", {6'd0, lane_oe}, 8'h3);
      drive(0,0,0,1,1);
      drive(0,0,0,0,1);
      check("R9 rmw write phase lane_we", {6'd0, lane_we}, 8'h3);
      check("R9 rmw write phase lane_oe", {6'd0, lane_oe}, 8'h0);
      drive(0,1,1,0,1);
      drive(0,1,1,1,1);
      expect_cyc(4'd5, 2'b11, "R9 rmw");
      drive(1,1,1,1,1);

      // R3 row-only refresh, OE low does nothing
      drive(0,1,1,1,0);
      check("R3 row only lane_oe", {6'd0, lane_oe}, 8'h0);
      expect_cyc(4'd6, 2'b00, "R3 row only");
      drive(1,1,1,1,1);

      // R2 CBR with only lower strobe low, WE low inside
      drive(1,1,0,1,1);
      drive(0,1,0,1,1);
      drive(0,1,0,0,0);
      check("R2 cbr lane_we", {6'd0, lane_we}, 8'h0);
      check("R2 cbr lane_oe", {6'd0, lane_oe}, 8'h0);
      drive(0,1,0,1,1);
      expect_cyc(4'd7, 2'b00, "R2 cbr lower");
      drive(1,1,1,1,1);

      // R2 CBR with only upper strobe low
      drive(1,0,1,1,1);
      drive(0,0,1,1,1);
      expect_cyc(4'd7, 2'b00, "R2 cbr upper");
      drive(1,1,1,1,1);

      // R10 WE fall after window closed
      drive(0,1,1,1,1);
      drive(0,1,0,1,1);
      drive(0,1,1,1,1);
      drive(0,1,1,0,1);
      check("R10 bad lane_we", {6'd0, lane_we}, 8'h0);
      drive(0,1,1,1,1);
      expect_cyc(4'd15, 2'b01, "R10 unrecognized");
      drive(1,1,1,1,1);

      // R12 staggered strobes: lower first, upper last, WE under upper only
      drive(0,1,1,1,1);
      drive(0,1,0,1,1);
      drive(0,0,0,1,1);
      drive(0,0,1,1,1);
      drive(0,0,1,0,1);
      check("R12 staggered lane_we", {6'd0, lane_we}, 8'h2);
      drive(0,1,1,0,1);
      drive(0,1,1,1,1);
      expect_cyc(4'd4, 2'b11, "R12 staggered delayed");
      drive(1,1,1,1,1);

      // R11 row strobe high, other pins active
      drive(1,0,0,0,0);
      check("R11 idle lane_oe", {6'd0, lane_oe}, 8'h0);
      check("R11 idle lane_we", {6'd0, lane_we}, 8'h0);
      check("R11 idle valid", {7'd0, cyc_valid}, 8'd0);
      drive(1,1,1,1,1);

      repeat (10) @(negedge clk);
      check("R1 pulse count", 8'(n_pulse), 8'(n_push));
      check("R1 queue drained", 8'(sb.size()), 8'd0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule